// File: doc/BRIEF.md
# Paired Byte GPIO Port with Per-Port Interrupt Vectors

The block holds two byte-wide general-purpose I/O ports behind one synchronous register bus. Each configuration and data register is 16 bits wide. The low byte belongs to port A and the high byte to port B. Two byte strobes select which halves a write touches, so software can update one port without a read-modify-write of the other.

Each pin has these controls:
- a direction bit and an output bit, held apart from the sampled input level;
- a pull-select bit;
- an interrupt enable;
- an edge polarity bit;
- a pending flag.

Input pins pass through a two-flop synchronizer before edge detection. Each port has its own interrupt request and its own encoded vector, which names the lowest-numbered pending pin. Reading a vector acknowledges that pin's flag. The pair has no combined vector.

Port B may implement fewer than eight pins. The missing positions ignore writes, read as zero and never drive.

Top module: `gpio_pair_top`

## Requirements
- R1: After synchronous reset, every register reads 0, `pin_oe` and `pin_o` are 0, both `irq_*` are low and both vectors read 0.
- R2: `pin_oe` bit i equals direction register bit i (1 = drive), and `pin_o` equals the output register (register address 1; direction is at address 2).
- R3: The input register (address 0) returns the pin levels after a two-flop synchronizer: a level applied just after one rising edge reads back after the second following rising edge. It is unaffected by the output register.
- R4: A write with `strb` = 2'b11 updates all 16 bits of the addressed register (output 1, direction 2, pull 3, enable 4, polarity 5, flag 6).
- R5: A write with `strb` = 2'b01 changes only bits 7:0, and one with 2'b10 only bits 15:8. The other byte keeps its value.
- R6: Port B implements `HI_PINS` pins (default 6). Bits 15:8+`HI_PINS` of every register ignore writes, read 0 and never drive `pin_oe`.
- R7: Polarity bit 0 selects a rising edge and 1 a falling edge. A transition of the other direction sets no flag.
- R8: A qualifying pin edge applied just after a rising clock edge sets its flag on the third rising edge, so `irq_*` rises then if the pin is enabled.
- R9: Vector A (address 7) and vector B (address 8) each read 0 with no pending flag in their port, otherwise 2×(n+1) for the lowest pending pin n. Each covers only its own port.
- R10: A read (`re`) of a vector clears only the flag it reports. Writes to vector addresses have no effect.
- R11: Writing the flag register stores the written bits, so a 1 sets a flag and a 0 clears it.
- R12: `irq_a` (`irq_b`) is high exactly while some flag of port A (B) is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| strb | input | 2 | Byte lane enables, bit 0 low byte |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable, acknowledges vector reads |
| rdata | output | 16 | Read data for `addr` |
| pin_i | input | 16 | Pin input levels |
| pin_o | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables |
| irq_a | output | 1 | Port A interrupt request |
| irq_b | output | 1 | Port B interrupt request |

## Verification
The bench targets the following corner cases and the fault each would expose:
- **Byte-lane writes.** A design that wrote whole words would corrupt the untouched byte.
- **Unimplemented upper pins.** Storing those bits would make them read back nonzero.
- **Flag timing.** Skipping a synchronizer stage would raise the request a cycle early.
- **Two pins firing together.** A design that prioritised the highest pin would return the wrong vector first.
- **Acknowledging through a vector read.** Clearing the whole port, or the other port, would lose a pending flag.
- **Edges of the wrong polarity.** An inverted polarity select would set flags on those edges.
- **Writes to the vector addresses.** These must be ignored; a design that let them through would disturb flags.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;

    parameter int PORT_W = 8;
    parameter int NPORT  = 2;
    parameter int DATA_W = PORT_W * NPORT;
    parameter int REG_AW = 4;
    parameter int VEC_W  = $clog2(2 * PORT_W + 1);

    typedef enum logic [REG_AW-1:0] {
        REG_IN    = 4'd0,
        REG_OUT   = 4'd1,
        REG_DIR   = 4'd2,
        REG_PULL  = 4'd3,
        REG_IE    = 4'd4,
        REG_POL   = 4'd5,
        REG_FLAG  = 4'd6,
        REG_VEC_A = 4'd7,
        REG_VEC_B = 4'd8
    } reg_sel_e;

    // Per-port register file contents
    typedef struct packed {
        logic [PORT_W-1:0] dout;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] pull;
        logic [PORT_W-1:0] ie;
        logic [PORT_W-1:0] pol;
        logic [PORT_W-1:0] flag;
    } port_regs_t;

    // Per-port command derived from one bus cycle
    typedef struct packed {
        logic              wr_out;
        logic              wr_dir;
        logic              wr_pull;
        logic              wr_ie;
        logic              wr_pol;
        logic              wr_flag;
        logic              rd_vec;
        logic [PORT_W-1:0] data;
    } port_cmd_t;

    // Priority encoder: lowest pending pin wins, code 2*(n+1), 0 if none
    function automatic logic [VEC_W-1:0] vec_encode(input logic [PORT_W-1:0] f);
        logic [VEC_W-1:0] v;
        v = '0;
        for (int i = PORT_W - 1; i >= 0; i--) begin
            if (f[i]) v = VEC_W'(2 * (i + 1));
        end
        return v;
    endfunction

    // Isolate the lowest set bit
    function automatic logic [PORT_W-1:0] lowest_one(input logic [PORT_W-1:0] f);
        return f & (~f + PORT_W'(1));
    endfunction

    function automatic logic [PORT_W-1:0] impl_mask(input int pins);
        return PORT_W'((64'(1) << pins) - 64'(1));
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/gpio_regdec.sv
module gpio_regdec
    import gpio_pair_pkg::*;
(
    input  logic [REG_AW-1:0]            addr,
    input  logic                         we,
    input  logic                         re,
    input  logic [NPORT-1:0]             strb,
    input  logic [DATA_W-1:0]            wdata,
    output port_cmd_t [NPORT-1:0]        cmd
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    for (genvar g = 0; g < NPORT; g++) begin : g_lane
        logic lane_we;
        assign lane_we = we && strb[g];

        always_comb begin
            cmd[g].data    = wdata[g*PORT_W +: PORT_W];
            cmd[g].wr_out  = lane_we && (sel == REG_OUT);
            cmd[g].wr_dir  = lane_we && (sel == REG_DIR);
            cmd[g].wr_pull = lane_we && (sel == REG_PULL);
            cmd[g].wr_ie   = lane_we && (sel == REG_IE);
            cmd[g].wr_pol  = lane_we && (sel == REG_POL);
            cmd[g].wr_flag = lane_we && (sel == REG_FLAG);
            cmd[g].rd_vec  = re && (sel == ((g == 0) ? REG_VEC_A : REG_VEC_B));
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pair_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  port_cmd_t         cmd,
    input  logic [PORT_W-1:0] pin_i,
    output logic [PORT_W-1:0] pin_o,
    output logic [PORT_W-1:0] pin_oe,
    output port_regs_t        regs,
    output logic [PORT_W-1:0] level,
    output logic [VEC_W-1:0]  vec,
    output logic              irq
);
    localparam logic [PORT_W-1:0] IMPL = impl_mask(PINS);

    port_regs_t        r_q;
    logic [PORT_W-1:0] prev_q;
    logic [PORT_W-1:0] lvl;
    logic [PORT_W-1:0] rise;
    logic [PORT_W-1:0] fall;
    logic [PORT_W-1:0] hit;
    logic [PORT_W-1:0] ack;
    logic [PORT_W-1:0] flag_base;
    logic [PORT_W-1:0] wmask_data;

    gpio_sync #(.W(PORT_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_i & IMPL),
        .q   (lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
    assign hit  = ((rise & ~r_q.pol) | (fall & r_q.pol)) & IMPL;

    assign vec        = vec_encode(r_q.flag);
    assign ack        = cmd.rd_vec ? lowest_one(r_q.flag) : '0;
    assign wmask_data = cmd.data & IMPL;
    assign flag_base  = cmd.wr_flag ? wmask_data : r_q.flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            if (cmd.wr_out)  r_q.dout <= wmask_data;
            if (cmd.wr_dir)  r_q.dir  <= wmask_data;
            if (cmd.wr_pull) r_q.pull <= wmask_data;
            if (cmd.wr_ie)   r_q.ie   <= wmask_data;
            if (cmd.wr_pol)  r_q.pol  <= wmask_data;
            r_q.flag <= ((flag_base & ~ack) | hit) & IMPL;
        end
    end

    assign pin_o  = r_q.dout;
    assign pin_oe = r_q.dir;
    assign regs   = r_q;
    assign level  = lvl;
    assign irq    = |(r_q.flag & r_q.ie);
endmodule

// File: rtl/gpio_pair_top.sv
module gpio_pair_top
    import gpio_pair_pkg::*;
#(
    parameter int LO_PINS = 8,
    parameter int HI_PINS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [REG_AW-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NPORT-1:0]     strb,
    input  logic                 we,
    input  logic                 re,
    output logic [DATA_W-1:0]    rdata,
    input  logic [DATA_W-1:0]    pin_i,
    output logic [DATA_W-1:0]    pin_o,
    output logic [DATA_W-1:0]    pin_oe,
    output logic                 irq_a,
    output logic                 irq_b
);
    port_cmd_t  [NPORT-1:0]             cmd;
    port_regs_t [NPORT-1:0]             regs_q;
    logic       [NPORT-1:0][PORT_W-1:0] lvl_q;
    logic       [NPORT-1:0][VEC_W-1:0]  vec_q;
    logic       [NPORT-1:0]             irq_q;

    gpio_regdec u_dec (
        .addr  (addr),
        .we    (we),
        .re    (re),
        .strb  (strb),
        .wdata (wdata),
        .cmd   (cmd)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        gpio_port #(.PINS((g == 0) ? LO_PINS : HI_PINS)) u_port (
            .clk    (clk),
            .rst    (rst),
            .cmd    (cmd[g]),
            .pin_i  (pin_i[g*PORT_W +: PORT_W]),
            .pin_o  (pin_o[g*PORT_W +: PORT_W]),
            .pin_oe (pin_oe[g*PORT_W +: PORT_W]),
            .regs   (regs_q[g]),
            .level  (lvl_q[g]),
            .vec    (vec_q[g]),
            .irq    (irq_q[g])
        );
    end

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(addr))
            REG_IN:    for (int g = 0; g < NPORT; g++) rdata[g*PORT_W +: PORT_W] = lvl_q[g];
            REG_OUT:   for (int g = 0; g < NPORT; g++) rdata[g*PORT_W +: PORT_W] = regs_q[g].dout;
            REG_DIR:   for (int g = 0; g < NPORT; g++) rdata[g*PORT_W +: PORT_W] = regs_q[g].dir;
            REG_PULL:  for (int g = 0; g < NPORT; g++) rdata[g*PORT_W +: PORT_W] = regs_q[g].pull;
            REG_IE:    for (int g = 0; g < NPORT; g++) rdata[g*PORT_W +: PORT_W] = regs_q[g].ie;
            REG_POL:   for (int g = 0; g < NPORT; g++) rdata[g*PORT_W +: PORT_W] = regs_q[g].pol;
            REG_FLAG:  for (int g = 0; g < NPORT; g++) rdata[g*PORT_W +: PORT_W] = regs_q[g].flag;
            REG_VEC_A: rdata = DATA_W'(vec_q[0]);
            REG_VEC_B: rdata = DATA_W'(vec_q[1]);
            default:   rdata = '0;
        endcase
    end

    assign irq_a = irq_q[0];
    assign irq_b = irq_q[1];
endmodule

// File: rtl/gpio_pair_chk.sv
module gpio_pair_chk
    import gpio_pair_pkg::*;
#(
    parameter int LO_PINS = 8,
    parameter int HI_PINS = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic [REG_AW-1:0]    addr,
    input logic                 we,
    input logic [NPORT-1:0]     strb,
    input logic [DATA_W-1:0]    wdata,
    input logic [DATA_W-1:0]    pin_o,
    input logic [DATA_W-1:0]    pin_oe,
    input logic                 irq_a,
    input logic                 irq_b,
    input logic [VEC_W-1:0]     vec_a,
    input logic [VEC_W-1:0]     vec_b
);
    localparam logic [PORT_W-1:0] LO_M = impl_mask(LO_PINS);
    localparam logic [PORT_W-1:0] HI_M = impl_mask(HI_PINS);

    assert_reset_oe_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0 && pin_o == '0 && !irq_a && !irq_b));

    assert_dir_full_R4: assert property (@(posedge clk) disable iff (rst)
        (we && addr == REG_DIR && strb == 2'b11) |=> pin_oe == ($past(wdata) & {HI_M, LO_M}));

    assert_lane_low_only_R5: assert property (@(posedge clk) disable iff (rst)
        (we && addr == REG_OUT && strb == 2'b01) |=> $stable(pin_o[DATA_W-1:PORT_W]));

    assert_lane_high_only_R5: assert property (@(posedge clk) disable iff (rst)
        (we && addr == REG_OUT && strb == 2'b10) |=> $stable(pin_o[PORT_W-1:0]));

    assert_no_drive_unimpl_R6: assert property (@(posedge clk) disable iff (rst)
        (pin_oe[DATA_W-1:PORT_W] & ~HI_M) == '0);

    assert_vec_code_R9: assert property (@(posedge clk) disable iff (rst)
        !vec_a[0] && !vec_b[0] && vec_a <= VEC_W'(2 * PORT_W) && vec_b <= VEC_W'(2 * PORT_W));

    assert_irq_a_pending_R12: assert property (@(posedge clk) disable iff (rst)
        irq_a |-> vec_a != '0);

    assert_irq_b_pending_R12: assert property (@(posedge clk) disable iff (rst)
        irq_b |-> vec_b != '0);
endmodule

bind gpio_pair_top gpio_pair_chk #(.LO_PINS(LO_PINS), .HI_PINS(HI_PINS)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .we     (we),
    .strb   (strb),
    .wdata  (wdata),
    .pin_o  (pin_o),
    .pin_oe (pin_oe),
    .irq_a  (irq_a),
    .irq_b  (irq_b),
    .vec_a  (vec_q[0]),
    .vec_b  (vec_q[1])
);

// File: tb/gpio_pair_top_tb_top.sv
module gpio_pair_top_tb_top;
    localparam int CLK_P = 10;

    localparam logic [3:0] A_IN = 0, A_OUT = 1, A_DIR = 2, A_IE = 4, A_POL = 5,
                           A_FLAG = 6, A_VA = 7, A_VB = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  strb = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [15:0] rdata;
    logic [15:0] pin_i = '0;
    logic [15:0] pin_o;
    logic [15:0] pin_oe;
    logic        irq_a;
    logic        irq_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        int          kind;   // 0 rdata, 1 pin_o, 2 pin_oe, 3 {irq_b, irq_a}
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;

    always #(CLK_P/2) clk = ~clk;

    gpio_pair_top dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .strb(strb),
        .we(we), .re(re), .rdata(rdata), .pin_i(pin_i), .pin_o(pin_o),
        .pin_oe(pin_oe), .irq_a(irq_a), .irq_b(irq_b)
    );

    // Monitor: pops expected items and compares against the design
    initial begin
        forever begin
            item_t it;
            logic [15:0] act;
            @(sample_ev);
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = rdata;
                1:       act = pin_o;
                2:       act = pin_oe;
                default: act = {14'd0, irq_b, irq_a};
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_val(input int kind, input logic [15:0] exp, input string tag);
        item_t it;
        #1;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] s);
        @(negedge clk);
        addr = a; wdata = d; strb = s; we = 1'b1;
        @(negedge clk);
        we = 1'b0; strb = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        addr = a; re = 1'b1;
        expect_val(0, exp, tag);
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        pin_i = v;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_val(2, 16'h0000, "R1 pin_oe after reset");
        expect_val(1, 16'h0000, "R1 pin_o after reset");
        expect_val(3, 16'h0000, "R1 irq after reset");
        rd(A_DIR,  16'h0000, "R1 dir reset");
        rd(A_FLAG, 16'h0000, "R1 flag reset");
        rd(A_VA,   16'h0000, "R1 vector A reset");
        rd(A_VB,   16'h0000, "R1 vector B reset");

        // R4 / R6 full-width write, upper unimplemented bits
        wr(A_DIR, 16'hFFFF, 2'b11);
        rd(A_DIR, 16'h3FFF, "R4 R6 dir full write");
        expect_val(2, 16'h3FFF, "R2 pin_oe follows dir");
        wr(A_OUT, 16'h1234, 2'b11);
        expect_val(1, 16'h1234, "R2 pin_o follows out");

        // R5 byte lanes
        wr(A_OUT, 16'hABCD, 2'b01);
        rd(A_OUT, 16'h12CD, "R5 low lane only");
        wr(A_OUT, 16'h5600, 2'b10);
        rd(A_OUT, 16'h16CD, "R5 high lane only");
        wr(A_OUT, 16'hFFFF, 2'b10);
        rd(A_OUT, 16'h3FCD, "R6 unimplemented bits drop");
        expect_val(1, 16'h3FCD, "R2 pin_o after lanes");

        // R3 input synchronizer and separation from output
        set_pins(16'hFFA5);
        rd(A_IN, 16'h0000, "R3 input not yet synchronized");
        rd(A_IN, 16'h3FA5, "R3 input after two stages");
        wr(A_FLAG, 16'h0000, 2'b11);
        rd(A_FLAG, 16'h0000, "R11 write zero clears flags");

        // R8 / R12 timing of a rising edge on A1
        wr(A_IE, 16'h0003, 2'b11);
        wr(A_POL, 16'h0100, 2'b11);
        set_pins(16'hFFA7);
        @(negedge clk); expect_val(3, 16'h0000, "R8 no irq after one edge");
        @(negedge clk); expect_val(3, 16'h0000, "R8 no irq after two edges");
        @(negedge clk); expect_val(3, 16'h0001, "R8 R12 irq_a on third edge");
        rd(A_VA, 16'h0004, "R9 vector pin 1");
        rd(A_FLAG, 16'h0000, "R10 vector read acknowledged");
        expect_val(3, 16'h0000, "R12 irq drops after ack");

        // R9 priority with two simultaneous edges, disabled pins
        set_pins(16'hFFEF);
        settle();
        expect_val(3, 16'h0000, "R12 disabled flags give no irq");
        rd(A_VA, 16'h0008, "R9 lowest pin 3 first");
        rd(A_VA, 16'h000E, "R9 R10 pin 6 next");
        rd(A_VA, 16'h0000, "R9 empty vector");

        // R7 polarity: B0 falling selected, A0 falling not selected
        set_pins(16'hFEEE);
        settle();
        rd(A_VB, 16'h0002, "R7 falling edge on B0");
        rd(A_VA, 16'h0000, "R7 falling edge ignored on A0");

        // R11 software set, R10 vector write ignored and per-port ack
        wr(A_FLAG, 16'h2010, 2'b11);
        rd(A_FLAG, 16'h2010, "R11 software set flags");
        wr(A_VB, 16'hFFFF, 2'b11);
        rd(A_FLAG, 16'h2010, "R10 vector write ignored");
        rd(A_VB, 16'h000C, "R9 vector B pin 5");
        rd(A_FLAG, 16'h0010, "R10 ack clears only port B flag");
        expect_val(3, 16'h0000, "R12 flag not enabled");
        wr(A_IE, 16'h0010, 2'b01);
        expect_val(3, 16'h0001, "R12 enable raises irq_a");
        wr(A_FLAG, 16'h0000, 2'b01);
        expect_val(3, 16'h0000, "R12 irq_a falls when flag cleared");

        done = 1;
        summary();
        $finish;
    end
endmodule